// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Responder

This block sits beside a 16-bit processor bus as an external interrupt controller. It watches a set of interrupt source lines, records a pending request when a source line rises, and pulls a shared active-low request line to the processor while any source is pending. The processor answers a request with an interrupt-acknowledge bus cycle. The block recognises that cycle from the function code and the address strobe, and picks the lowest-numbered pending source. It then returns that source's 8-bit vector number on the low data lanes and acknowledges the cycle. If nothing is pending, it signals a bus error and returns no vector.

Each source has a vector register that software loads through a simple write port. The processor multiplies the vector by four to index a 256-entry handler table. Numbers 0 to 63 belong to hardware exceptions, and that range includes the two reset entries. A number written below 64 is therefore raised to 64, so the block only ever supplies user vectors. The pending bit of the serviced source clears when its acknowledge cycle ends.

Top module: `vec_irq_responder`

## Requirements
- R1: A rising edge on src_req[i], sampled at a clock edge, sets pending bit i at that edge. irq_n is low while any bit is pending. A line held high does not set its bit again after the bit is cleared.
- R2: The vector register of source i resets to 64+i. A write with cfg_we=1 stores cfg_vec into register cfg_idx at the clock edge. A value below 64 is stored as 64, and values 64 to 255 are stored unchanged.
- R3: A cycle is an acknowledge cycle only when fc equals 3'b111 and as_n is low. With any other fc value the block keeps dtack_n and berr_n high and vec_oe low.
- R4: At the first clock edge that samples an acknowledge cycle, the lowest-numbered pending source is chosen. Its vector appears on vec_data[7:0] with vec_oe high only while ds_n is low in that acknowledged cycle. Otherwise vec_data is high impedance and vec_oe is low.
- R5: dtack_n goes low from the clock edge that first samples the acknowledge cycle with a source pending. It returns high at the clock edge that samples as_n high.
- R6: An acknowledge cycle that finds nothing pending drives berr_n low for the same span instead of dtack_n, and drives no vector.
- R7: The chosen source's pending bit clears at the clock edge that ends its acknowledge cycle. A new rising edge on that source at the same edge keeps the bit set.
- R8: The chosen source stays fixed for the whole acknowledge cycle. A lower-numbered source that becomes pending during the cycle does not change the returned vector.
- R9: After reset no source is pending, irq_n, dtack_n and berr_n are high, and vec_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | NUM_SRC | Interrupt source lines, rising edge requests |
| cfg_we | input | 1 | Vector register write enable |
| cfg_idx | input | IDX_W | Source index for a vector write |
| cfg_vec | input | 8 | Vector number to write |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Low-lane data strobe, active low |
| fc | input | 3 | Processor function code |
| irq_n | output | 1 | Interrupt request to the processor, active low |
| vec_data | output | 8 | Vector number on the low data lanes, high impedance when idle |
| vec_oe | output | 1 | High while vec_data is driven |
| dtack_n | output | 1 | Cycle acknowledge, active low |
| berr_n | output | 1 | Bus error for an empty acknowledge, active low |

## Verification
The bench builds the block with its default of four sources. With four sources, both the highest-priority and lowest-priority sources can be serviced in one run. It also allows a simultaneous pair of requests and a late lower-numbered arrival during a cycle. The vector values used reach both ends of the user range and one value below it that must be clamped. The scenarios also cover a data strobe that lags the address strobe, a request edge that coincides with the end of its own acknowledge, and a wrong function code.

// File: rtl/vir_pkg.sv
// Package: shared constants for the vectored interrupt responder.
// Assumes an 8-bit vector and a 3-bit function code bus.
package vir_pkg;
    localparam int          VEC_W        = 8;
    localparam int          FC_W         = 3;
    localparam logic [7:0]  USER_VEC_MIN = 8'd64;
    localparam logic [2:0]  FC_IACK      = 3'b111;
endpackage

// File: rtl/irq_pend_ctrl.sv
// irq_pend_ctrl: captures source rising edges into pending bits and picks
// the lowest-numbered pending source. Assumes src_req is synchronous to clk.
module irq_pend_ctrl #(
    parameter int NUM_SRC = 4,
    parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [NUM_SRC-1:0] pending,
    output logic               any_pend,
    output logic [IDX_W-1:0]   win_idx
);
    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] clr_vec;

    assign rise = src_req & ~src_q;

    // Decode the clear request into a one-hot mask.
    always_comb begin
        clr_vec = '0;
        if (clr_en) clr_vec[clr_idx] = 1'b1;
    end

    // Remember the previous source levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_req;
    end

    // Set on a rising edge, clear on service; a new edge wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= '0;
        else        pending <= (pending & ~clr_vec) | rise;
    end

    // Lowest-numbered pending source has priority.
    always_comb begin
        win_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pending[i]) win_idx = IDX_W'(i);
        end
    end

    assign any_pend = |pending;

    // R7: a serviced source without a fresh edge is no longer pending.
    a_r7_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !rise[clr_idx]) |=> !pending[$past(clr_idx)]);

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_set_chk
            // R1: a sampled rising edge always leaves the bit pending.
            a_r1_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
                rise[g] |=> pending[g]);
        end
    endgenerate
endmodule

// File: rtl/irq_vec_regs.sv
// irq_vec_regs: one vector register per source, loaded by a write port and
// clamped into the user range. Assumes writes to an index >= NUM_SRC are dropped.
module irq_vec_regs
    import vir_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [VEC_W-1:0] cfg_vec,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [VEC_W-1:0] rd_vec
);
    logic [VEC_W-1:0] vec_q [NUM_SRC];
    logic [VEC_W-1:0] wr_val;

    // Raise any value in the reserved range to the first user vector.
    assign wr_val = (cfg_vec < USER_VEC_MIN) ? USER_VEC_MIN : cfg_vec;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_vec
            // Per-source register with reset default 64+g.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    vec_q[g] <= USER_VEC_MIN + VEC_W'(g);
                else if (cfg_we && (cfg_idx == IDX_W'(g)))
                    vec_q[g] <= wr_val;
            end

            // R2: no stored vector ever falls into the reserved range.
            a_r2_user_range: assert property (@(posedge clk) disable iff (!rst_n)
                vec_q[g] >= USER_VEC_MIN);
        end
    endgenerate

    // Read the register of the chosen source.
    always_comb begin
        rd_vec = vec_q[0];
        for (int i = 0; i < NUM_SRC; i++) begin
            if (rd_idx == IDX_W'(i)) rd_vec = vec_q[i];
        end
    end
endmodule

// File: rtl/iack_seq.sv
// iack_seq: tracks one interrupt-acknowledge bus cycle, freezes the winning
// source at its start and drives acknowledge, bus error and data enable.
// Assumes as_n stays low for the whole cycle and ds_n only falls inside it.
module iack_seq
    import vir_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             as_n,
    input  logic             ds_n,
    input  logic [FC_W-1:0]  fc,
    input  logic             any_pend,
    input  logic [IDX_W-1:0] win_idx,
    output logic [IDX_W-1:0] sel_idx,
    output logic             clr_en,
    output logic             drive_en,
    output logic             dtack_n,
    output logic             berr_n
);
    logic iack;
    logic active;
    logic hit_q;

    assign iack = (fc == FC_IACK) && !as_n;

    // Open the cycle on its first sampled edge; close it when the strobe drops.
    always_ff @(posedge clk) begin
        if (!rst_n)                active <= 1'b0;
        else if (iack && !active)  active <= 1'b1;
        else if (!iack)            active <= 1'b0;
    end

    // Freeze the winner and whether anything was pending at cycle start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_idx <= '0;
            hit_q   <= 1'b0;
        end else if (iack && !active) begin
            sel_idx <= win_idx;
            hit_q   <= any_pend;
        end
    end

    assign clr_en   = active && !iack && hit_q;
    assign drive_en = active && hit_q && !ds_n;
    assign dtack_n  = !(active && hit_q);
    assign berr_n   = !(active && !hit_q);

    // R5/R6: never acknowledge and fault the same cycle.
    a_r5_single_reply: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dtack_n && !berr_n));

    // R6: an empty acknowledge cycle yields a bus error on the next cycle.
    a_r6_empty_berr: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && !active && !any_pend) |=> !berr_n);

    // R3: without an acknowledge cycle the block stays silent.
    a_r3_silent_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!iack && !$past(iack)) |-> (dtack_n && berr_n));
endmodule

// File: rtl/vec_irq_responder.sv
// vec_irq_responder: top of the vectored interrupt responder. Joins the
// pending logic, vector registers and acknowledge sequencer.
// Assumes bus inputs are synchronous to clk; NUM_SRC is 2..192.
module vec_irq_responder
    import vir_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [7:0]         cfg_vec,
    input  logic               as_n,
    input  logic               ds_n,
    input  logic [2:0]         fc,
    output logic               irq_n,
    output logic [7:0]         vec_data,
    output logic               vec_oe,
    output logic               dtack_n,
    output logic               berr_n
);
    logic [NUM_SRC-1:0] pending;
    logic               any_pend;
    logic [IDX_W-1:0]   win_idx;
    logic [IDX_W-1:0]   sel_idx;
    logic               clr_en;
    logic               drive_en;
    logic [VEC_W-1:0]   sel_vec;

    irq_pend_ctrl #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_req  (src_req),
        .clr_en   (clr_en),
        .clr_idx  (sel_idx),
        .pending  (pending),
        .any_pend (any_pend),
        .win_idx  (win_idx)
    );

    irq_vec_regs #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_idx (cfg_idx),
        .cfg_vec (cfg_vec),
        .rd_idx  (sel_idx),
        .rd_vec  (sel_vec)
    );

    iack_seq #(.IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .as_n     (as_n),
        .ds_n     (ds_n),
        .fc       (fc),
        .any_pend (any_pend),
        .win_idx  (win_idx),
        .sel_idx  (sel_idx),
        .clr_en   (clr_en),
        .drive_en (drive_en),
        .dtack_n  (dtack_n),
        .berr_n   (berr_n)
    );

    // Request line and the low data lanes.
    assign irq_n    = !any_pend;
    assign vec_oe   = drive_en;
    assign vec_data = drive_en ? sel_vec : 8'bz;

    // R4: data lanes are only driven under an active data strobe.
    a_r4_drive_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> (!ds_n && !dtack_n));
endmodule

// File: tb/vec_irq_responder_tb.sv
// Directed bench for vec_irq_responder: one task per scenario.
module vec_irq_responder_tb;
    localparam int NUM_SRC = 4;
    localparam int IDX_W   = 2;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [NUM_SRC-1:0] src_req;
    logic               cfg_we;
    logic [IDX_W-1:0]   cfg_idx;
    logic [7:0]         cfg_vec;
    logic               as_n, ds_n;
    logic [2:0]         fc;
    logic               irq_n, vec_oe, dtack_n, berr_n;
    wire  [7:0]         vec_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    vec_irq_responder #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_vec(cfg_vec), .as_n(as_n), .ds_n(ds_n),
        .fc(fc), .irq_n(irq_n), .vec_data(vec_data), .vec_oe(vec_oe),
        .dtack_n(dtack_n), .berr_n(berr_n)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input int idx);
        @(negedge clk) src_req[idx] = 1'b1;
        @(negedge clk) src_req[idx] = 1'b0;
    endtask

    task automatic wr(input int idx, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_vec = 8'(val);
        @(negedge clk) cfg_we = 1'b0;
    endtask

    // Full acknowledge cycle with strobes together; checks reply and release.
    task automatic run_ack(input string req, input bit hit, input int vec);
        @(negedge clk);
        fc = 3'b111; as_n = 1'b0; ds_n = 1'b0;
        @(negedge clk);
        check({req, " dtack_n"}, dtack_n, !hit);
        check({req, " berr_n"}, berr_n, hit);
        check({req, " vec_oe"}, vec_oe, hit);
        if (hit) check({req, " vector"}, vec_data, vec);
        as_n = 1'b1; ds_n = 1'b1; fc = 3'b000;
        #1 check("R4 oe drops with ds_n", vec_oe, 0);
        @(negedge clk);
        check("R5 dtack_n released", dtack_n, 1);
        check("R6 berr_n released", berr_n, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; src_req = '0; cfg_we = 1'b0; cfg_idx = '0; cfg_vec = '0;
        as_n = 1'b1; ds_n = 1'b1; fc = 3'b000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 irq_n", irq_n, 1);
        check("R9 dtack_n", dtack_n, 1);
        check("R9 berr_n", berr_n, 1);
        check("R9 vec_oe", vec_oe, 0);
    endtask

    task automatic t_empty();
        run_ack("R6 empty", 1'b0, 0);
    endtask

    task automatic t_wrong_fc();
        pulse(2);
        check("R1 irq_n after edge", irq_n, 0);
        @(negedge clk);
        fc = 3'b110; as_n = 1'b0; ds_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R3 dtack_n on fc=6", dtack_n, 1);
        check("R3 berr_n on fc=6", berr_n, 1);
        check("R3 vec_oe on fc=6", vec_oe, 0);
        as_n = 1'b1; ds_n = 1'b1; fc = 3'b000;
        run_ack("R2 default vector src2", 1'b1, 66);
        check("R7 irq_n after service", irq_n, 1);
    endtask

    task automatic t_priority();
        wr(1, 200);
        wr(3, 10);
        wr(0, 255);
        pulse(3);
        pulse(1);
        run_ack("R4 lowest first", 1'b1, 200);
        check("R7 irq_n still low", irq_n, 0);
        run_ack("R2 clamped vector", 1'b1, 64);
        check("R7 irq_n after both", irq_n, 1);
    endtask

    task automatic t_late_ds();
        pulse(0);
        @(negedge clk);
        fc = 3'b111; as_n = 1'b0; ds_n = 1'b1;
        @(negedge clk);
        check("R5 dtack_n before ds", dtack_n, 0);
        check("R4 no drive before ds", vec_oe, 0);
        ds_n = 1'b0;
        #1 check("R4 drive with ds", vec_oe, 1);
        check("R2 vector 255", vec_data, 255);
        @(negedge clk);
        as_n = 1'b1; ds_n = 1'b1; fc = 3'b000;
        @(negedge clk);
        check("R5 dtack_n after as_n high", dtack_n, 1);
        check("R7 irq_n", irq_n, 1);
    endtask

    task automatic t_frozen();
        pulse(3);
        @(negedge clk);
        fc = 3'b111; as_n = 1'b0; ds_n = 1'b0; src_req[0] = 1'b1;
        @(negedge clk);
        src_req[0] = 1'b0;
        check("R8 frozen vector", vec_data, 64);
        @(negedge clk);
        check("R8 still frozen", vec_data, 64);
        as_n = 1'b1; ds_n = 1'b1; fc = 3'b000;
        @(negedge clk);
        check("R8 late source pending", irq_n, 0);
        run_ack("R8 late source served", 1'b1, 255);
    endtask

    task automatic t_coincide();
        pulse(2);
        @(negedge clk);
        fc = 3'b111; as_n = 1'b0; ds_n = 1'b0;
        @(negedge clk);
        check("R7 vector src2", vec_data, 66);
        as_n = 1'b1; ds_n = 1'b1; fc = 3'b000; src_req[2] = 1'b1;
        @(negedge clk);
        src_req[2] = 1'b0;
        check("R7 new edge kept pending", irq_n, 0);
        run_ack("R7 re-served src2", 1'b1, 66);
    endtask

    task automatic t_level_hold();
        @(negedge clk) src_req[0] = 1'b1;
        @(negedge clk);
        check("R1 level sets", irq_n, 0);
        run_ack("R1 served", 1'b1, 255);
        repeat (2) @(negedge clk);
        check("R1 held level no re-arm", irq_n, 1);
        src_req[0] = 1'b0;
    endtask

    initial begin
        t_reset();
        t_empty();
        t_wrong_fc();
        t_priority();
        t_late_ds();
        t_frozen();
        t_coincide();
        t_level_hold();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule